// File: doc/BRIEF.md
# Partial Reconfiguration Host Sequencer

This block runs one partial-reconfiguration event against a target configuration port. A one-cycle start request, taken while the sequencer is idle, raises a freeze output. The freeze output holds the logic of the region being rebuilt steady. The block then raises a request to the target and waits for the target to report that it is ready. After that it takes bitstream words from a valid/ready sink and passes each one to the target as a 16-bit word, marked by a one-cycle clock strobe.

The event ends when the target reports done. It also ends when any fault line fires: a programming error, a CRC error, or a bitstream-identity mismatch raised by an outside checker. The block then drops the request and releases freeze. A 3-bit status code records the outcome and holds until the next event starts.

Two options shape the event:
- A double-cycle input, seen at any point during the event, makes the block run two request/stream passes before releasing freeze.
- A clock-to-data ratio parameter of 1, 2 or 4 spaces out the words accepted. Plain data uses 1, encrypted data uses 2 and compressed data uses 4.

Top module: `pr_host_seq`

## Requirements
- R1: `status_o` codes are: 3'b000 after reset, 3'b100 while an event is in progress (the whole time `freeze_o` is high), 3'b101 after a successful event. Codes 3'b110 and 3'b111 never appear.
- R2: A fault seen during an event sets the status and ends the event. `tgt_err_i` sets 3'b001, `tgt_crc_i` sets 3'b010 and `tgt_bad_id_i` sets 3'b011. When several fault lines are high in the same cycle, `tgt_err_i` wins over `tgt_crc_i`, and `tgt_crc_i` wins over `tgt_bad_id_i`.
- R3: An error code holds while idle until `start_i` is sampled high with `freeze_o` low. One clock after that, the status is 3'b100.
- R4: `freeze_o` rises one clock after `start_i` is sampled high while idle. It stays high until the event ends. `start_i` has no effect while `freeze_o` is high.
- R5: A word is taken only on a clock where `in_valid_i` and `in_ready_o` are both high. One clock later it appears on `tgt_data_o`, with `tgt_clk_o` high for that one cycle.
- R6: `in_ready_o` is high only while streaming. With ratio N, after a word is accepted `in_ready_o` stays low for N-1 clocks. Strobes are therefore at least N clocks apart.
- R7: After the target reports done, `in_ready_o` and `tgt_req_o` are low. Further valid words produce no strobe.
- R8: If `double_i` is high at the start or at any clock during the event, the block runs two passes. Between the passes `tgt_req_o` drops for exactly one clock while `freeze_o` stays high. Freeze is released, with status 3'b101, after the second done.
- R9: A CRC error seen while idle after a successful event changes the status from 3'b101 to 3'b010.
- R10: Driving `rst_n` low immediately, without waiting for a clock, forces status 3'b000 and drives freeze, request and strobe low.
- R11: `freeze_o` and `tgt_req_o` are low one clock after a fault is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins an event when sampled high while idle |
| double_i | input | 1 | Requests two reconfiguration passes |
| in_data_i | input | DATA_W | Incoming bitstream word |
| in_valid_i | input | 1 | `in_data_i` carries a word |
| in_ready_o | output | 1 | Sink can take a word this clock |
| freeze_o | output | 1 | Holds the region under rebuild |
| status_o | output | 3 | Latched outcome code |
| tgt_req_o | output | 1 | Request to the target port |
| tgt_clk_o | output | 1 | One-cycle strobe per forwarded word |
| tgt_data_o | output | DATA_W | Word forwarded to the target |
| tgt_ready_i | input | 1 | Target can receive data |
| tgt_done_i | input | 1 | Target finished a pass |
| tgt_err_i | input | 1 | Target programming error |
| tgt_crc_i | input | 1 | Target CRC error |
| tgt_bad_id_i | input | 1 | Bitstream identity mismatch from an outside checker |

## Verification
The bench runs three copies of the block side by side, one for each ratio, because pacing faults appear only at ratios above 1. A design that miscounts phases would accept words back to back at ratio 2 or 4 and lose them in the target.

The bench raises several fault lines in the same cycle to check the priority order. A wrong order would report a CRC error where a programming error occurred. It pulses start in the middle of an event; a design that restarted there would clear a live status. It also checks that a CRC error while idle changes a success code but leaves an error code alone.

Double-pass runs count the request rises and freeze falls. A design that dropped freeze between the passes would release a half-built region. A final asynchronous reset in the middle of a stream must clear the outputs at once, without waiting for a clock edge.

// File: rtl/pr_host_pkg.sv
`timescale 1ns/1ps
package pr_host_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        S_IDLE,
        S_REQ,
        S_STREAM,
        S_GAP
    } seq_state_e;

    localparam logic [2:0] CODE_RESET   = 3'b000;
    localparam logic [2:0] CODE_TGT_ERR = 3'b001;
    localparam logic [2:0] CODE_CRC     = 3'b010;
    localparam logic [2:0] CODE_BAD_ID  = 3'b011;
    localparam logic [2:0] CODE_BUSY    = 3'b100;
    localparam logic [2:0] CODE_PASS    = 3'b101;

    typedef struct packed {
        seq_state_e st;
        logic [2:0] code;
        logic       dbl;
        logic       second;
    } seq_regs_t;

endpackage

// File: rtl/pr_pace_ctr.sv
`timescale 1ns/1ps
// Phase counter that spaces accepted words RATIO clocks apart.
module pr_pace_ctr #(
    parameter int RATIO = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic accept_i,
    output logic slot_o
);
    localparam int PH_W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [PH_W-1:0] LAST = PH_W'(RATIO - 1);

    logic [PH_W-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        if (!run_i) begin
            phase_d = '0;
        end else if (accept_i || phase_q != '0) begin
            phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    assign slot_o = (phase_q == '0);
endmodule

// File: rtl/pr_word_fwd.sv
`timescale 1ns/1ps
// Registers each accepted word and raises a one-cycle strobe with it.
module pr_word_fwd #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [DATA_W-1:0] din_i,
    output logic              strobe_o,
    output logic [DATA_W-1:0] dout_o
);
    logic              strobe_d, strobe_q;
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        strobe_d = accept_i;
        data_d   = accept_i ? din_i : data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            data_q   <= '0;
        end else begin
            strobe_q <= strobe_d;
            data_q   <= data_d;
        end
    end

    assign strobe_o = strobe_q;
    assign dout_o   = data_q;
endmodule

// File: rtl/pr_host_seq.sv
`timescale 1ns/1ps
// Sequencer for one reconfiguration event: freeze, request, stream, status.
module pr_host_seq
    import pr_host_pkg::*;
#(
    parameter int RATIO  = 1,
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              double_i,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    output logic              freeze_o,
    output logic [2:0]        status_o,
    output logic              tgt_req_o,
    output logic              tgt_clk_o,
    output logic [DATA_W-1:0] tgt_data_o,
    input  logic              tgt_ready_i,
    input  logic              tgt_done_i,
    input  logic              tgt_err_i,
    input  logic              tgt_crc_i,
    input  logic              tgt_bad_id_i
);
    seq_regs_t r_d, r_q;
    logic      streaming, slot, accept, fault;

    assign streaming = (r_q.st == S_STREAM);
    assign accept    = in_valid_i && in_ready_o;
    assign fault     = (r_q.st != S_IDLE) && (tgt_err_i || tgt_crc_i || tgt_bad_id_i);

    pr_pace_ctr #(.RATIO(RATIO)) u_pace (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (streaming),
        .accept_i (accept),
        .slot_o   (slot)
    );

    pr_word_fwd #(.DATA_W(DATA_W)) u_fwd (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .din_i    (in_data_i),
        .strobe_o (tgt_clk_o),
        .dout_o   (tgt_data_o)
    );

    always_comb begin
        r_d = r_q;
        if (r_q.st == S_IDLE) begin
            if (start_i) begin
                r_d.st     = S_REQ;
                r_d.code   = CODE_BUSY;
                r_d.dbl    = double_i;
                r_d.second = 1'b0;
            end else if (r_q.code == CODE_PASS && tgt_crc_i) begin
                r_d.code = CODE_CRC;
            end
        end else begin
            r_d.dbl = r_q.dbl | double_i;
            if (fault) begin
                r_d.st = S_IDLE;
                if (tgt_err_i)      r_d.code = CODE_TGT_ERR;
                else if (tgt_crc_i) r_d.code = CODE_CRC;
                else                r_d.code = CODE_BAD_ID;
            end else begin
                unique case (r_q.st)
                    S_REQ: begin
                        if (tgt_ready_i) r_d.st = S_STREAM;
                    end
                    S_STREAM: begin
                        if (tgt_done_i) begin
                            if (r_d.dbl && !r_q.second) begin
                                r_d.st     = S_GAP;
                                r_d.second = 1'b1;
                            end else begin
                                r_d.st   = S_IDLE;
                                r_d.code = CODE_PASS;
                            end
                        end
                    end
                    S_GAP:   r_d.st = S_REQ;
                    default: r_d.st = S_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, code: CODE_RESET, dbl: 1'b0, second: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready_o = streaming && slot;
    assign freeze_o   = (r_q.st != S_IDLE);
    assign tgt_req_o  = (r_q.st == S_REQ) || streaming;
    assign status_o   = r_q.code;
endmodule

// File: rtl/pr_host_seq_chk.sv
`timescale 1ns/1ps
module pr_host_seq_chk #(
    parameter int RATIO = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       in_valid_i,
    input logic       in_ready_o,
    input logic       freeze_o,
    input logic [2:0] status_o,
    input logic       tgt_req_o,
    input logic       tgt_clk_o,
    input logic       tgt_err_i
);
    p_code_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != 3'b110) && (status_o != 3'b111));

    p_busy_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_o |-> (status_o == 3'b100));

    p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze_o && start_i) |=> (freeze_o && status_o == 3'b100));

    p_req_in_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req_o |-> freeze_o);

    p_strobe_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> tgt_clk_o);

    p_ready_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> tgt_req_o);

    p_strobe_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_clk_o |-> $past(in_valid_i && in_ready_o));

    p_err_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_o && tgt_err_i) |=> (!freeze_o && !tgt_req_o));

    generate
        if (RATIO > 1) begin : g_paced
            p_pace_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid_i && in_ready_o) |=> !in_ready_o);
        end
    endgenerate
endmodule

bind pr_host_seq pr_host_seq_chk #(.RATIO(RATIO)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .freeze_o   (freeze_o),
    .status_o   (status_o),
    .tgt_req_o  (tgt_req_o),
    .tgt_clk_o  (tgt_clk_o),
    .tgt_err_i  (tgt_err_i)
);

// File: tb/pr_host_seq_test.sv
`timescale 1ns/1ps
// One lane: a DUT at a given ratio, a behavioural target and a reference model.
module pr_host_lane #(
    parameter int RATIO = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       dbl,
    input  logic       src_valid,
    input  logic       idle_crc,
    input  int         n_words,
    input  int         err_at,
    input  int         crc_at,
    input  int         bad_at,
    output logic       freeze,
    output logic       req,
    output logic       strobe,
    output logic [2:0] status,
    output int         checks,
    output int         fails
);
    logic        in_ready;
    logic [15:0] in_data    = 16'h0;
    logic [15:0] tgt_data;
    logic        tgt_ready  = 1'b0;
    logic        tgt_done   = 1'b0;
    logic        tgt_err    = 1'b0;
    logic        tgt_crc    = 1'b0;
    logic        tgt_bad    = 1'b0;

    pr_host_seq #(.RATIO(RATIO)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .double_i     (dbl),
        .in_data_i    (in_data),
        .in_valid_i   (src_valid),
        .in_ready_o   (in_ready),
        .freeze_o     (freeze),
        .status_o     (status),
        .tgt_req_o    (req),
        .tgt_clk_o    (strobe),
        .tgt_data_o   (tgt_data),
        .tgt_ready_i  (tgt_ready),
        .tgt_done_i   (tgt_done),
        .tgt_err_i    (tgt_err),
        .tgt_crc_i    (tgt_crc),
        .tgt_bad_id_i (tgt_bad)
    );

    // Reference model. Phase: 0 idle, 1 request, 2 stream, 3 between passes.
    int          m_phase = 0;
    int          m_code  = 0;
    bit          m_dbl   = 0;
    bit          m_sec   = 0;
    int          m_slot  = 0;
    bit          m_str   = 0;
    logic [15:0] m_dat   = 16'h0;

    always @(posedge clk or negedge rst_n) begin : ref_model
        bit took;
        if (!rst_n) begin
            m_phase = 0; m_code = 0; m_dbl = 0; m_sec = 0;
            m_slot = 0; m_str = 0; m_dat = 16'h0;
        end else begin
            took  = src_valid && (m_phase == 2) && (m_slot == 0);
            m_str = took;
            if (took) m_dat = in_data;
            if (m_phase == 2) begin
                if (took || m_slot != 0) m_slot = (m_slot + 1) % RATIO;
            end else begin
                m_slot = 0;
            end
            if (m_phase == 0) begin
                if (start) begin
                    m_phase = 1; m_code = 4; m_dbl = dbl; m_sec = 0;
                end else if (m_code == 5 && tgt_crc) begin
                    m_code = 2;
                end
            end else begin
                m_dbl = m_dbl | dbl;
                if (tgt_err)      begin m_phase = 0; m_code = 1; end
                else if (tgt_crc) begin m_phase = 0; m_code = 2; end
                else if (tgt_bad) begin m_phase = 0; m_code = 3; end
                else if (m_phase == 1) begin
                    if (tgt_ready) m_phase = 2;
                end else if (m_phase == 2) begin
                    if (tgt_done) begin
                        if (m_dbl && !m_sec) begin m_phase = 3; m_sec = 1; end
                        else begin m_phase = 0; m_code = 5; end
                    end
                end else begin
                    m_phase = 1;
                end
            end
        end
    end

    initial begin
        checks = 0;
        fails  = 0;
    end

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s ratio %0d %s: got %0d expected %0d at %0t", tag, RATIO, what, act, exp, $time);
        end
    endtask

    int req_age   = 0;
    int words     = 0;
    bit done_sent = 0;
    int cyc       = 0;

    always @(negedge clk) begin
        cmp("R4",  "freeze",   int'(freeze),   int'(m_phase != 0));
        cmp("R11", "request",  int'(req),      int'(m_phase == 1 || m_phase == 2));
        cmp("R6",  "in_ready", int'(in_ready), int'(m_phase == 2 && m_slot == 0));
        cmp("R1",  "status",   int'(status),   m_code);
        cmp("R5",  "strobe",   int'(strobe),   int'(m_str));
        cmp("R5",  "data",     int'(tgt_data), int'(m_dat));
        // behavioural target
        cyc++;
        if (!req) begin
            req_age = 0; words = 0; done_sent = 0;
        end else begin
            req_age++;
        end
        if (strobe) words++;
        tgt_ready = req && (req_age >= 3);
        tgt_done  = 1'b0;
        if (req && words >= n_words && !done_sent) begin
            tgt_done  = 1'b1;
            done_sent = 1;
        end
        tgt_err = req && (err_at != 0) && (words == err_at);
        tgt_crc = (req && (crc_at != 0) && (words == crc_at)) || idle_crc;
        tgt_bad = req && (bad_at != 0) && (words == bad_at);
        in_data = 16'(cyc * 16'h1357 + RATIO);
    end
endmodule

module pr_host_seq_test;
    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic dbl   = 1'b0;
    logic src_valid = 1'b0;
    logic idle_crc  = 1'b0;
    int   n_words = 6;
    int   err_at  = 0;
    int   crc_at  = 0;
    int   bad_at  = 0;

    logic       fr  [3];
    logic       rq  [3];
    logic       sb  [3];
    logic [2:0] st  [3];
    int         lchk[3];
    int         lfail[3];

    int n_checks = 0;
    int n_fails  = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;   // 50 MHz

    genvar gi;
    generate
        for (gi = 0; gi < 3; gi++) begin : g_lane
            pr_host_lane #(.RATIO(1 << gi)) lane (
                .clk(clk), .rst_n(rst_n), .start(start), .dbl(dbl),
                .src_valid(src_valid), .idle_crc(idle_crc),
                .n_words(n_words), .err_at(err_at), .crc_at(crc_at), .bad_at(bad_at),
                .freeze(fr[gi]), .req(rq[gi]), .strobe(sb[gi]), .status(st[gi]),
                .checks(lchk[gi]), .fails(lfail[gi])
            );
        end
    endgenerate

    // edge counters and strobe spacing, observed at the falling edge
    int  rises[3], falls[3], last_sb[3], min_gap[3];
    bit  prev_rq[3], prev_fr[3];
    int  tcyc = 0;
    initial begin
        for (int i = 0; i < 3; i++) begin
            rises[i] = 0; falls[i] = 0; last_sb[i] = -1000; min_gap[i] = 1000;
            prev_rq[i] = 0; prev_fr[i] = 0;
        end
    end
    always @(negedge clk) begin
        tcyc++;
        for (int i = 0; i < 3; i++) begin
            if (rq[i] && !prev_rq[i]) rises[i]++;
            if (!fr[i] && prev_fr[i]) falls[i]++;
            prev_rq[i] = rq[i];
            prev_fr[i] = fr[i];
            if (sb[i]) begin
                if (tcyc - last_sb[i] < min_gap[i]) min_gap[i] = tcyc - last_sb[i];
                last_sb[i] = tcyc;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #5;
        end
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic report();
        int tc, tf;
        tc = n_checks;
        tf = n_fails;
        for (int i = 0; i < 3; i++) begin
            tc += lchk[i];
            tf += lfail[i];
        end
        $display("  == %0d vectors applied, %0d miscompares ==", tc, tf);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        tick(1);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int c = 0; c < 3000; c++) begin
            if (!fr[0] && !fr[1] && !fr[2]) break;
            tick(1);
        end
        tick(2);
    endtask

    task automatic clear_faults();
        err_at = 0; crc_at = 0; bad_at = 0;
    endtask

    int r0[3], f0[3];

    initial begin : watchdog
        #(20 * 100000);
        if (!done_flag) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not end, got 0 expected 1");
            report();
            $finish;
        end
    end

    initial begin
        tick(3);
        for (int i = 0; i < 3; i++) begin
            check("R10", "freeze in reset", int'(fr[i]), 0);
            check("R1",  "status in reset", int'(st[i]), 0);
        end
        rst_n = 1'b1;
        src_valid = 1'b1;
        tick(2);

        // single pass, with a second start inside the event
        for (int i = 0; i < 3; i++) f0[i] = falls[i];
        pulse_start();
        for (int i = 0; i < 3; i++) begin
            check("R4", "freeze after start", int'(fr[i]), 1);
            check("R1", "busy code",          int'(st[i]), 3'b100);
        end
        tick(3);
        pulse_start();
        wait_idle();
        for (int i = 0; i < 3; i++) begin
            check("R1", "pass code",               int'(st[i]), 3'b101);
            check("R4", "one freeze release only", falls[i] - f0[i], 1);
        end
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < 3; i++) check("R7", "no strobe after done", int'(sb[i]), 0);
            tick(1);
        end

        // CRC error while idle after success
        idle_crc = 1'b1;
        tick(1);
        idle_crc = 1'b0;
        tick(1);
        for (int i = 0; i < 3; i++) check("R9", "idle crc after pass", int'(st[i]), 3'b010);

        // double pass, requested after the start
        for (int i = 0; i < 3; i++) begin r0[i] = rises[i]; f0[i] = falls[i]; end
        pulse_start();
        tick(1);
        dbl = 1'b1;
        wait_idle();
        dbl = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check("R8", "two request passes",  rises[i] - r0[i], 2);
            check("R8", "single freeze release", falls[i] - f0[i], 1);
            check("R8", "double pass code",    int'(st[i]), 3'b101);
        end

        // programming error, then hold while idle
        err_at = 3;
        pulse_start();
        wait_idle();
        clear_faults();
        for (int i = 0; i < 3; i++) check("R2", "target error code", int'(st[i]), 3'b001);
        idle_crc = 1'b1;
        tick(1);
        idle_crc = 1'b0;
        tick(4);
        for (int i = 0; i < 3; i++) check("R3", "error code held", int'(st[i]), 3'b001);

        // CRC error during the event; start clears the old code
        crc_at = 2;
        pulse_start();
        for (int i = 0; i < 3; i++) check("R3", "start clears code", int'(st[i]), 3'b100);
        wait_idle();
        clear_faults();
        for (int i = 0; i < 3; i++) check("R2", "crc code", int'(st[i]), 3'b010);

        // identity mismatch
        bad_at = 2;
        pulse_start();
        wait_idle();
        clear_faults();
        for (int i = 0; i < 3; i++) check("R2", "bad id code", int'(st[i]), 3'b011);

        // simultaneous faults: programming error wins
        err_at = 2; crc_at = 2; bad_at = 2;
        pulse_start();
        wait_idle();
        clear_faults();
        for (int i = 0; i < 3; i++) check("R2", "fault priority", int'(st[i]), 3'b001);

        // crc and mismatch together: crc wins
        crc_at = 1; bad_at = 1;
        pulse_start();
        wait_idle();
        clear_faults();
        for (int i = 0; i < 3; i++) check("R2", "crc over mismatch", int'(st[i]), 3'b010);

        for (int i = 0; i < 3; i++) check("R6", "strobe spacing", int'(min_gap[i] >= (1 << i)), 1);

        // asynchronous reset in the middle of a long stream
        n_words = 40;
        pulse_start();
        tick(8);
        rst_n = 1'b0;
        #1;
        for (int i = 0; i < 3; i++) begin
            check("R10", "freeze at async reset",  int'(fr[i]), 0);
            check("R10", "request at async reset", int'(rq[i]), 0);
            check("R10", "status at async reset",  int'(st[i]), 0);
        end
        tick(2);
        rst_n = 1'b1;
        tick(3);

        done_flag = 1;
        report();
        $finish;
    end
endmodule